// File: doc/BRIEF.md
# Serial Absolute Angle Readout Port

This block is the slave side of a three-wire serial link that hands a host a 12-bit absolute shaft angle. A position source elsewhere in the chip feeds it a live angle word. The host pulls chip-select low. The block then freezes the angle at that moment into a shift register and turns on its data driver. Each falling edge of the host's serial clock then moves the next bit onto the data line, most significant bit first.

The chip-select, serial clock and data pins are asynchronous to the block's system clock. The block resynchronises chip-select and serial clock through two-flop synchronizers and detects their edges in the system clock domain. Several ports can share one data wire. Each one drives the wire only while its own chip-select is low. The output enable tells the pad when to drive, and the data output is held at 0 whenever the pad is not driving.

A host that needs only a coarse angle may raise chip-select after any number of bits, and the next transfer starts clean. A host that keeps clocking past the twelfth bit receives zeros.

Top module: `angle_serial_port`

## Requirements
- R1: While chip-select is high, `data_oe_o` is 0 and `data_o` is 0. This holds from reset onward and within 4 clock cycles after chip-select rises, including when a transfer is cut short.
- R2: When chip-select goes low, the angle present on `angle_i` is captured and `data_oe_o` rises. `data_o` then shows bit 11 (the MSB) of the captured word.
- R3: Each falling edge of `sclk_i` while chip-select is low moves `data_o` to the next lower bit. After k falling edges, `data_o` shows bit 11-k, for k from 0 to 11. Rising edges of `sclk_i` do not shift.
- R4: Changes on `angle_i` after chip-select has fallen do not alter the bits delivered in that transfer.
- R5: From the twelfth falling edge onward, and for as long as chip-select stays low, `data_o` is 0. The bit counter stops at 12.
- R6: Raising chip-select after fewer than 12 bits ends the transfer. The next chip-select fall captures a fresh angle, and that transfer starts again at its MSB.
- R7: Serial clock edges while chip-select is high have no effect. The next transfer still starts at its MSB.
- R8: The outputs react to a chip-select fall on the third rising edge of `clk` after the new level is applied. This is two synchronizer stages plus the capture register. The output enable is still 0 one cycle after the fall.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than the serial clock |
| rst_n | input | 1 | Synchronous active-low reset |
| angle_i | input | 12 | Live absolute angle from the position source |
| cs_n_i | input | 1 | Chip-select from the host, active low, asynchronous |
| sclk_i | input | 1 | Serial clock from the host, idles high, asynchronous |
| data_o | output | 1 | Serial data bit, 0 when not driving |
| data_oe_o | output | 1 | Pad drive enable; the pad floats when it is 0 |

## Verification
The hardest case to reach from the pins is a transfer that overlaps a change in the source angle. The capture must hold the old word while the live input moves underneath it. To reach it, the bench changes `angle_i` twice during an active read: once right after chip-select falls and once midway through the bits. It then checks that all twelve bits match the word present at the fall.

The abort-and-restart path is also hard to reach. A cut-short transfer leaves the bit counter partly advanced. The bench stops after five bits, waits out the synchronizer delay and starts a new read, which must begin again at its MSB. Clocking sixteen edges drives the counter into saturation, and the trailing four bits must all be zero.

// File: rtl/angle_port_pkg.sv
// Shared definitions for the serial angle readout port.
// Assumes: a single system clock; host signals arrive asynchronously.
package angle_port_pkg;

    // Default angle word width and synchronizer depth
    localparam int unsigned DEF_ANGLE_W  = 12;
    localparam int unsigned DEF_SYNC_LEN = 2;

    // Idle levels of the host pins: chip-select high, serial clock high
    localparam logic CS_IDLE   = 1'b1;
    localparam logic SCLK_IDLE = 1'b1;

endpackage

// File: rtl/aport_sync.sv
// Multi-bit resynchronizer, one independent flop chain per bit.
// Assumes: each bit is a slow level from an unrelated clock domain;
// no bus coherency is required between bits.
module aport_sync #(
    parameter int unsigned WIDTH  = 2,
    parameter int unsigned STAGES = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    logic [STAGES-1:0] chain [WIDTH];

    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        // Shift the raw level through STAGES flops
        always_ff @(posedge clk) begin
            if (!rst_n) chain[b] <= {STAGES{RST_VAL[b]}};
            else        chain[b] <= {chain[b][STAGES-2:0], async_i[b]};
        end
        assign sync_o[b] = chain[b][STAGES-1];
    end

endmodule

// File: rtl/aport_fall_det.sv
// Falling-edge detector for already synchronized levels.
// Assumes: inputs are synchronous to clk; a one-cycle pulse per fall.
module aport_fall_det #(
    parameter int unsigned WIDTH = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] level_i,
    output logic [WIDTH-1:0] fall_o
);

    logic [WIDTH-1:0] prev_q;

    // Remember last cycle's level
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= RST_VAL;
        else        prev_q <= level_i;
    end

    assign fall_o = prev_q & ~level_i;

endmodule

// File: rtl/aport_shifter.sv
// Capture register, MSB-first shifter and saturating bit counter.
// Assumes: start, shift are single-cycle pulses; cs_high_i is a level.
// A high chip-select level overrides everything and ends a transfer.
module aport_shifter #(
    parameter int unsigned ANGLE_W = 12,
    localparam int unsigned CNT_W  = $clog2(ANGLE_W + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ANGLE_W-1:0] angle_i,
    input  logic               cs_high_i,
    input  logic               start_i,
    input  logic               shift_i,
    output logic               active_o,
    output logic               bit_o,
    output logic [CNT_W-1:0]   cnt_o
);

    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(ANGLE_W);

    logic               active_q;
    logic [ANGLE_W-1:0] sreg_q;
    logic [CNT_W-1:0]   cnt_q;

    // Transfer state: open on chip-select fall, close while chip-select high
    always_ff @(posedge clk) begin
        if (!rst_n)         active_q <= 1'b0;
        else if (cs_high_i) active_q <= 1'b0;
        else if (start_i)   active_q <= 1'b1;
    end

    // Snapshot on start, otherwise shift left with zero fill on each clock fall
    always_ff @(posedge clk) begin
        if (!rst_n)                            sreg_q <= '0;
        else if (cs_high_i)                    sreg_q <= '0;
        else if (start_i)                      sreg_q <= angle_i;
        else if (active_q && shift_i)          sreg_q <= {sreg_q[ANGLE_W-2:0], 1'b0};
    end

    // Count delivered bits, stopping at the word width
    always_ff @(posedge clk) begin
        if (!rst_n)                            cnt_q <= '0;
        else if (cs_high_i || start_i)         cnt_q <= '0;
        else if (active_q && shift_i && cnt_q != CNT_MAX)
                                               cnt_q <= cnt_q + 1'b1;
    end

    assign active_o = active_q;
    assign bit_o    = active_q & (cnt_q != CNT_MAX) & sreg_q[ANGLE_W-1];
    assign cnt_o    = cnt_q;

endmodule

// File: rtl/angle_serial_port.sv
// Top level of the serial absolute angle readout port.
// Assumes: clk is at least ~10x the serial clock rate, so that the host's
// setup waits cover the synchronizer delay.
module angle_serial_port #(
    parameter int unsigned ANGLE_W  = angle_port_pkg::DEF_ANGLE_W,
    parameter int unsigned SYNC_LEN = angle_port_pkg::DEF_SYNC_LEN
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ANGLE_W-1:0] angle_i,
    input  logic               cs_n_i,
    input  logic               sclk_i,
    output logic               data_o,
    output logic               data_oe_o
);

    localparam int unsigned CNT_W = $clog2(ANGLE_W + 1);
    localparam logic [1:0]  IDLE  = {angle_port_pkg::SCLK_IDLE, angle_port_pkg::CS_IDLE};

    logic [1:0]       pins_s;
    logic [1:0]       falls;
    logic             cs_s;
    logic             cs_fall;
    logic             sclk_fall;
    logic [CNT_W-1:0] bit_cnt;

    aport_sync #(.WIDTH(2), .STAGES(SYNC_LEN), .RST_VAL(IDLE)) sync_i (
        .clk(clk), .rst_n(rst_n), .async_i({sclk_i, cs_n_i}), .sync_o(pins_s)
    );

    aport_fall_det #(.WIDTH(2), .RST_VAL(IDLE)) fall_i (
        .clk(clk), .rst_n(rst_n), .level_i(pins_s), .fall_o(falls)
    );

    assign cs_s      = pins_s[0];
    assign cs_fall   = falls[0];
    assign sclk_fall = falls[1];

    aport_shifter #(.ANGLE_W(ANGLE_W)) shift_i (
        .clk(clk), .rst_n(rst_n), .angle_i(angle_i),
        .cs_high_i(cs_s), .start_i(cs_fall), .shift_i(sclk_fall),
        .active_o(data_oe_o), .bit_o(data_o), .cnt_o(bit_cnt)
    );

endmodule

// File: rtl/angle_port_chk.sv
// Property checker for angle_serial_port, attached by bind.
// Assumes: observes the synchronized chip-select and serial clock fall pulse.
module angle_port_chk #(
    parameter int unsigned ANGLE_W = 12,
    localparam int unsigned CNT_W  = $clog2(ANGLE_W + 1)
) (
    input logic               clk,
    input logic               rst_n,
    input logic [ANGLE_W-1:0] angle_i,
    input logic               data_o,
    input logic               data_oe_o,
    input logic               cs_n_s,
    input logic               sclk_fall,
    input logic [CNT_W-1:0]   bit_cnt
);

    // R1
    quiet_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !data_oe_o |-> !data_o);

    // R1
    off_after_cs_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n_s |=> !data_oe_o);

    // R2
    capture_msb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(data_oe_o) |-> data_o == $past(angle_i[ANGLE_W-1]));

    // R3
    hold_between_edges_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (data_oe_o && $past(data_oe_o) && !$past(sclk_fall)) |-> $stable(data_o));

    // R5
    zero_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (data_oe_o && bit_cnt == CNT_W'(ANGLE_W)) |-> !data_o);

    // R5
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bit_cnt <= CNT_W'(ANGLE_W));

endmodule

bind angle_serial_port angle_port_chk #(.ANGLE_W(ANGLE_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .angle_i(angle_i), .data_o(data_o),
    .data_oe_o(data_oe_o), .cs_n_s(cs_s), .sclk_fall(sclk_fall), .bit_cnt(bit_cnt)
);

// File: tb/angle_serial_port_tb.sv
// Directed bench for angle_serial_port: one task per scenario.
module angle_serial_port_tb_top;

    localparam int W    = 12;
    localparam int HALF = 100;   // serial clock half period in clk cycles

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] angle = '0;
    logic         cs_n = 1'b1;
    logic         sclk = 1'b1;
    logic         data_o;
    logic         data_oe_o;

    int n_chk  = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    angle_serial_port dut_i (
        .clk(clk), .rst_n(rst_n), .angle_i(angle), .cs_n_i(cs_n),
        .sclk_i(sclk), .data_o(data_o), .data_oe_o(data_oe_o)
    );

    task automatic check(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic cs_low();
        @(negedge clk); cs_n = 1'b0;
        wait_clk(150);
    endtask

    task automatic cs_high();
        @(negedge clk); cs_n = 1'b1;
        wait_clk(80);
    endtask

    // Read n bits: sample, then falling then rising serial clock edge
    task automatic read_bits(input string req, input logic [W-1:0] word, input int n);
        for (int i = 0; i < n; i++) begin
            check(req, data_o, (i < W) ? word[W-1-i] : 1'b0);
            check(req, data_oe_o, 1'b1);
            sclk = 1'b0; wait_clk(HALF);
            sclk = 1'b1; wait_clk(HALF);
        end
    endtask

    task automatic t_reset();
        check("R1 reset oe", data_oe_o, 1'b0);
        check("R1 reset data", data_o, 1'b0);
    endtask

    task automatic t_latency();
        angle = 12'h800;
        @(negedge clk); cs_n = 1'b0;
        wait_clk(1);
        check("R8 oe one cycle after fall", data_oe_o, 1'b0);
        wait_clk(2);
        check("R8 oe on third edge", data_oe_o, 1'b1);
        check("R8 msb on third edge", data_o, 1'b1);
        cs_high();
    endtask

    task automatic t_full_read();
        angle = 12'hA5C;
        cs_low();
        read_bits("R2 R3 full read", 12'hA5C, W);
        cs_high();
        check("R1 oe after read", data_oe_o, 1'b0);
    endtask

    task automatic t_change_during();
        angle = 12'h3C1;
        cs_low();
        angle = 12'hFFF;
        read_bits("R4 first half", 12'h3C1, 6);
        angle = 12'h000;
        for (int i = 6; i < W; i++) begin
            check("R4 second half", data_o, 12'h3C1 >> (W-1-i) & 1'b1);
            sclk = 1'b0; wait_clk(HALF);
            sclk = 1'b1; wait_clk(HALF);
        end
        cs_high();
    endtask

    task automatic t_overrun();
        angle = 12'h801;
        cs_low();
        read_bits("R5 overrun zeros", 12'h801, 16);
        cs_high();
    endtask

    task automatic t_abort();
        angle = 12'h5A5;
        cs_low();
        read_bits("R6 partial", 12'h5A5, 5);
        cs_high();
        check("R1 R6 oe after abort", data_oe_o, 1'b0);
        check("R1 R6 data after abort", data_o, 1'b0);
        angle = 12'h0F3;
        cs_low();
        read_bits("R6 restart", 12'h0F3, W);
        cs_high();
    endtask

    task automatic t_idle_clock();
        for (int i = 0; i < 5; i++) begin
            sclk = 1'b0; wait_clk(HALF);
            sclk = 1'b1; wait_clk(HALF);
            check("R7 idle clock oe", data_oe_o, 1'b0);
        end
        angle = 12'h9E7;
        cs_low();
        read_bits("R7 read after idle clock", 12'h9E7, W);
        cs_high();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual running expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        wait_clk(4);
        rst_n = 1'b1;
        wait_clk(4);
        t_reset();
        t_latency();
        t_full_read();
        t_change_during();
        t_overrun();
        t_abort();
        t_idle_clock();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule